// File: doc/BRIEF.md
# Indexed Address Generation Unit

This unit keeps two 16-bit pointer registers and turns either one into a memory address by adding a signed 8-bit offset. Each cycle a caller picks one of the two pointers and gives it one command: hold, load a 16-bit constant, step up by one, or step down by one. The offset and the constant arrive fully assembled from the decoder upstream, so the unit sees no instruction bytes.

The address output is combinational. It is formed from the pointer value that exists before the current cycle's update, so a caller can use a pointer and change it in the same cycle. The address path adds the low byte first. It then corrects the high byte with the carry out of the low byte. When the offset is negative, that carry is taken in inverted form, as a borrow. All arithmetic wraps modulo 2^16.

Top module: `idx_agu`

## Requirements
- R1: While `rst` is high at a rising edge, both pointers become 0000H at that edge.
- R2: With `op` = 2'b01 (load), the pointer chosen by `sel` (0 = first, 1 = second) takes the value of `imm` at the next rising edge.
- R3: With `op` = 2'b10 (increment), the chosen pointer grows by one at the next edge, and FFFFH wraps to 0000H.
- R4: With `op` = 2'b11 (decrement), the chosen pointer drops by one at the next edge, and 0000H wraps to FFFFH.
- R5: With `op` = 2'b00 (hold), neither pointer changes, and `imm` has no effect.
- R6: The pointer not chosen by `sel` never changes, whatever `op` is.
- R7: `ea` equals the chosen pointer plus `disp` sign-extended from bit 7, modulo 2^16. It is taken from the value before the current edge's update.
- R8: A non-negative offset (bit 7 clear) adds 0..127. For example, pointer 2050H with offset 40H gives 2090H.
- R9: A negative offset (bit 7 set) subtracts 1..128, and the inverted low-byte carry lowers the high byte. For example, 2185H with 9BH gives 2120H, and 0000H with 80H gives FF80H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Pointer choice: 0 first, 1 second |
| op | input | 2 | Command: 00 hold, 01 load, 10 increment, 11 decrement |
| imm | input | 16 | Constant for the load command |
| disp | input | 8 | Signed two's-complement offset |
| ea | output | 16 | Effective address of the chosen pointer plus offset |
| idx0 | output | 16 | Current first pointer |
| idx1 | output | 16 | Current second pointer |

## Verification
The in-line properties check every cycle that each pointer follows its command (load, step up, step down, hold) and that the pointer not chosen stays put. They also check that the byte-wise address path agrees with a plain 16-bit sign-extended sum. Only the bench's scenarios can show particular outcomes: the wrap of a pointer across FFFFH and 0000H, and the exact addresses where the high byte has to move up or down. The bench also shows that the address uses the pointer value from before the same cycle's change.

// File: rtl/idx_agu_pkg.sv
package idx_agu_pkg;

    localparam int unsigned PTR_W  = 16;
    localparam int unsigned OFS_W  = 8;
    localparam int unsigned NUM_PTR = 2;
    localparam int unsigned HALF_W = PTR_W / 2;
    localparam int unsigned SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'b00,
        CMD_LOAD = 2'b01,
        CMD_INC  = 2'b10,
        CMD_DEC  = 2'b11
    } cmd_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } ptr_split_t;

    function automatic ptr_t sext_ofs(input ofs_t o);
        return {{(PTR_W-OFS_W){o[OFS_W-1]}}, o};
    endfunction

endpackage

// File: rtl/idx_ptr_cell.sv
module idx_ptr_cell
    import idx_agu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  cmd_e cmd,
    input  ptr_t imm,
    output ptr_t q
);

    ptr_t nxt;

    always_comb begin
        nxt = q;
        if (en) begin
            unique case (cmd)
                CMD_LOAD: nxt = imm;
                CMD_INC:  nxt = q + ptr_t'(1);
                CMD_DEC:  nxt = q - ptr_t'(1);
                default:  nxt = q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (q == '0));

    // R2
    a_r2_load_imm: assert property (@(posedge clk) disable iff (rst)
        (en && cmd == CMD_LOAD) |=> (q == $past(imm)));

    // R3
    a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
        (en && cmd == CMD_INC) |=> (q == ptr_t'($past(q) + 1'b1)));

    // R4
    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (en && cmd == CMD_DEC) |=> (q == ptr_t'($past(q) - 1'b1)));

    // R5 and R6
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (!en || cmd == CMD_HOLD) |=> $stable(q));

endmodule

// File: rtl/idx_ea_adder.sv
module idx_ea_adder
    import idx_agu_pkg::*;
(
    input  ptr_t base,
    input  ofs_t ofs,
    output ptr_t ea
);

    ptr_split_t        b;
    ptr_split_t        r;
    logic [HALF_W:0]   lo_sum;
    logic              cy;
    logic              neg;

    assign b = base;
    assign neg = ofs[OFS_W-1];

    always_comb begin
        lo_sum = {1'b0, b.lo} + {1'b0, ofs};
        cy     = lo_sum[HALF_W];
        r.lo   = lo_sum[HALF_W-1:0];
        if (neg) begin
            // borrow is the inverted carry of the low add
            r.hi = b.hi - {{(HALF_W-1){1'b0}}, ~cy};
        end else begin
            r.hi = b.hi + {{(HALF_W-1){1'b0}}, cy};
        end
    end

    assign ea = r;

endmodule

// File: rtl/idx_agu.sv
module idx_agu
    import idx_agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sel,
    input  logic [1:0]  op,
    input  logic [15:0] imm,
    input  logic [7:0]  disp,
    output logic [15:0] ea,
    output logic [15:0] idx0,
    output logic [15:0] idx1
);

    ptr_t ptr_q [NUM_PTR];
    ptr_t base;
    cmd_e cmd;

    assign cmd = cmd_e'(op);

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        idx_ptr_cell u_cell (
            .clk (clk),
            .rst (rst),
            .en  (SEL_W'(sel) == SEL_W'(g)),
            .cmd (cmd),
            .imm (imm),
            .q   (ptr_q[g])
        );
    end

    assign base = ptr_q[sel];

    idx_ea_adder u_adder (
        .base (base),
        .ofs  (disp),
        .ea   (ea)
    );

    assign idx0 = ptr_q[0];
    assign idx1 = ptr_q[1];

    // R7: byte-wise adder agrees with a plain sign-extended 16-bit sum
    a_r7_ea_sum: assert property (@(posedge clk) disable iff (rst)
        ea == ptr_t'((sel ? idx1 : idx0) + sext_ofs(disp)));

    // R8/R9: address offset lies in -128..+127 of the chosen pointer
    a_r9_ofs_window: assert property (@(posedge clk) disable iff (rst)
        ptr_t'(ea - (sel ? idx1 : idx0) + 16'd128) < 16'd256);

endmodule

// File: tb/idx_agu_tb.sv
module idx_agu_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel;
    logic [1:0]  op;
    logic [15:0] imm;
    logic [7:0]  disp;
    logic [15:0] ea, idx0, idx1;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    idx_agu u_dut (
        .clk(clk), .rst(rst), .sel(sel), .op(op), .imm(imm), .disp(disp),
        .ea(ea), .idx0(idx0), .idx1(idx1)
    );

    // {sel, op, imm, disp, ea before edge, idx0 after, idx1 after}
    localparam int NV = 15;
    localparam logic [90:0] VEC [NV] = '{
        {1'b0, 2'b01, 16'h2050, 8'h40, 16'h0040, 16'h2050, 16'h0000}, // R2 R8
        {1'b1, 2'b01, 16'h2185, 8'h00, 16'h0000, 16'h2050, 16'h2185}, // R2 R6
        {1'b0, 2'b00, 16'h0000, 8'h40, 16'h2090, 16'h2050, 16'h2185}, // R8
        {1'b1, 2'b00, 16'h0000, 8'h9B, 16'h2120, 16'h2050, 16'h2185}, // R9
        {1'b1, 2'b10, 16'h0000, 8'hFF, 16'h2184, 16'h2050, 16'h2186}, // R3 R9
        {1'b0, 2'b11, 16'h0000, 8'h80, 16'h1FD0, 16'h204F, 16'h2186}, // R4 R9
        {1'b0, 2'b01, 16'hFFFF, 8'h01, 16'h2050, 16'hFFFF, 16'h2186}, // R7
        {1'b0, 2'b10, 16'h0000, 8'h01, 16'h0000, 16'h0000, 16'h2186}, // R3 wrap
        {1'b0, 2'b11, 16'h0000, 8'h7F, 16'h007F, 16'hFFFF, 16'h2186}, // R4 wrap
        {1'b1, 2'b01, 16'h0000, 8'h80, 16'h2106, 16'hFFFF, 16'h0000}, // R7
        {1'b1, 2'b00, 16'h0000, 8'h80, 16'hFF80, 16'hFFFF, 16'h0000}, // R9 wrap
        {1'b1, 2'b11, 16'h0000, 8'hFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R4
        {1'b0, 2'b00, 16'h1234, 8'h00, 16'hFFFF, 16'hFFFF, 16'hFFFF}, // R5
        {1'b1, 2'b01, 16'h2100, 8'h00, 16'hFFFF, 16'hFFFF, 16'h2100}, // R2
        {1'b1, 2'b00, 16'h0000, 8'hFF, 16'h20FF, 16'hFFFF, 16'h2100}  // R9
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; sel = 1'b0; op = 2'b00; imm = '0; disp = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 idx0", idx0, 16'h0000);
        check("R1 idx1", idx1, 16'h0000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {sel, op, imm, disp} = VEC[i][90:48];
            #1;
            check("R7 ea", ea, VEC[i][47:32]);
            @(posedge clk);
            #1;
            check("R2-6 idx0", idx0, VEC[i][31:16]);
            check("R2-6 idx1", idx1, VEC[i][15:0]);
            @(negedge clk);
        end

        // R5: imm ignored under hold, pointer still readable unchanged
        sel = 1'b1; op = 2'b00; imm = 16'hABCD; disp = 8'h00;
        @(posedge clk); #1;
        check("R5 idx1", idx1, 16'h2100);
        @(negedge clk);

        // R1: reset mid-run clears both pointers
        rst = 1'b1; op = 2'b10;
        @(posedge clk); #1;
        check("R1 idx0", idx0, 16'h0000);
        check("R1 idx1", idx1, 16'h0000);
        @(negedge clk);
        rst = 1'b0; op = 2'b00; sel = 1'b0; disp = 8'h80;
        #1;
        check("R9 ea", ea, 16'hFF80);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule